// File: doc/BRIEF.md
# TDM Audio Capture Slot Router

This block captures a time-division-multiplexed serial audio stream and turns it into 32-bit words for a capture DMA path. The serial bit clock, word select and five candidate data pins are oversampled in the system clock domain. One data pin is chosen by a select input. Each frame is cut into 8-bit slots. The byte received in a slot is steered by a programmable per-slot entry. It can go into one byte lane of a 32-bit assembly word, into one byte of one of two 32-bit feedback buffers, or nowhere at all.

An entry can also ask for the assembly word to be stored. The stored word enters a 24-deep input FIFO, and a valid/ready pop port drains that FIFO. Software writes the slot table and can write either feedback buffer directly, so a buffer can also hold a control or status value. Capture can sample on either edge of the bit clock.

Top module: `tdm_capture_router`

## Requirements
- R1: After reset, pop_valid, overflow, fb1_q and fb2_q are all 0, and every slot table entry is 0, which means invalid.
- R2: A frame begins at the bit that is sampled with ws high after a sample with ws low. That bit is the most significant bit of slot 0. Each slot is 8 bits, sent most significant bit first.
- R3: A slot entry is 8 bits. Bit 7 is valid, bit 6 is store, bit 5 is end-of-frame and bits 3:0 are the destination. Destinations 0 to 3 write the byte into assembly lane k, which is word bits [8k+7:8k]. A set store bit pushes the assembly word into the FIFO, including the current slot's byte, and then clears the word to zero.
- R4: Destinations 4 to 7 write byte (dest-4) of fb1_q. Destinations 8 to 11 write byte (dest-8) of fb2_q. Destinations 12 to 15 discard the byte.
- R5: When an entry's valid bit is 0, the slot's byte is discarded and no store happens. The slot index still advances.
- R6: After a slot whose entry has the end-of-frame bit set, or after slot 31, the next slot without a new frame start is slot 0.
- R7: The FIFO holds 24 words and returns them in push order. pop_valid is high when the FIFO is not empty. pop_data shows the oldest word, and that word is removed on a clock where pop_valid and pop_ready are both high.
- R8: A store request while the FIFO is full drops the word and sets overflow. Overflow then stays set until reset.
- R9: With bclk_inv low, data is sampled on rising bclk edges. With bclk_inv high, data is sampled on falling edges.
- R10: sd_sel values 0 to 4 pick the matching sd pin. Values 5 to 7 capture constant zero bits.
- R11: A software write with fb_we high loads fb_wdata into fb1_q when fb_sel is 0, or into fb2_q when fb_sel is 1. If a captured byte targets the same buffer in the same clock, the software write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than bclk |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| ws | input | 1 | Word select, rising level marks frame start |
| sd | input | 5 | Candidate serial data pins |
| sd_sel | input | 3 | Index of the data pin used for capture |
| bclk_inv | input | 1 | Sample on falling bclk edges when high |
| tsl_we | input | 1 | Slot table write strobe |
| tsl_addr | input | 5 | Slot table entry index |
| tsl_wdata | input | 8 | Slot table entry value |
| fb_we | input | 1 | Feedback buffer write strobe |
| fb_sel | input | 1 | Feedback buffer select (0 = fb1, 1 = fb2) |
| fb_wdata | input | 32 | Feedback buffer write value |
| fb1_q | output | 32 | Feedback buffer 1 contents |
| fb2_q | output | 32 | Feedback buffer 2 contents |
| pop_valid | output | 1 | FIFO holds at least one word |
| pop_data | output | 32 | Oldest FIFO word |
| pop_ready | input | 1 | Consumer takes the word shown |
| overflow | output | 1 | Sticky flag for a dropped store |

## Verification
The delay to each result is counted from the clk edge that first sees an active bclk edge. Two synchronizer flops come first, then one edge-compare cycle, then a registered byte strobe. The byte strobe updates the feedback buffers and the FIFO on the next edge, so both results are due about five clk cycles after the active edge of a slot's last bit.

The bench holds each bclk phase for four clk cycles, so a slot's result lands well inside the following bit time. Feedback buffers are read twelve clk cycles after a frame's last bit. FIFO words are not checked at a fixed cycle. A monitor compares each word against a queue of expected words, in order, on the falling clk edge of the cycle where the word is popped. The bench then confirms that the queue has drained.

// File: rtl/tdm_pkg.sv
// Package: shared slot entry layout and destination codes for the
// TDM capture router. Assumes 8-bit entries and 4 byte lanes per word.
package tdm_pkg;
    typedef struct packed {
        logic       valid;
        logic       store;
        logic       eof;
        logic       spare;
        logic [3:0] dest;
    } slot_entry_t;

    // upper two destination bits pick the target group
    localparam logic [1:0] GRP_LANE = 2'd0;
    localparam logic [1:0] GRP_FB1  = 2'd1;
    localparam logic [1:0] GRP_FB2  = 2'd2;
    localparam logic [1:0] GRP_DROP = 2'd3;
endpackage

// File: rtl/tdm_bit_rx.sv
// Serial receiver: synchronizes bclk/ws/sd into clk, detects the active
// bclk edge, aligns to a rising ws and emits one byte strobe per 8 bits.
// Assumes clk is at least 6x faster than bclk and ws/sd stable at the edge.
module tdm_bit_rx #(
    parameter int SD_PINS = 5,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bclk,
    input  logic               ws,
    input  logic [SD_PINS-1:0] sd,
    input  logic [SEL_W-1:0]   sd_sel,
    input  logic               bclk_inv,
    output logic               byte_done,
    output logic [7:0]         byte_data,
    output logic               byte_sof
);
    logic [1:0]         bclk_sy;
    logic [1:0]         ws_sy;
    logic [SD_PINS-1:0] sd_sy0;
    logic [SD_PINS-1:0] sd_sy1;
    logic               bclk_d;
    logic               samp;
    logic               sd_bit;
    logic               ws_prev;
    logic               wsr;
    logic               locked;
    logic               sof_pend;
    logic [2:0]         bit_cnt;
    logic [6:0]         shreg;

    // two-flop synchronizers plus a delayed bclk for edge compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_sy <= '0;
            ws_sy   <= '0;
            sd_sy0  <= '0;
            sd_sy1  <= '0;
            bclk_d  <= 1'b0;
        end else begin
            bclk_sy <= {bclk_sy[0], bclk};
            ws_sy   <= {ws_sy[0], ws};
            sd_sy0  <= sd;
            sd_sy1  <= sd_sy0;
            bclk_d  <= bclk_sy[1];
        end
    end

    // active edge: rising normally, falling when inverted
    assign samp = bclk_inv ? (bclk_d & ~bclk_sy[1]) : (~bclk_d & bclk_sy[1]);
    assign wsr  = ws_sy[1] & ~ws_prev;

    // pick the selected data pin, out-of-range selects read zero
    always_comb begin
        sd_bit = 1'b0;
        for (int i = 0; i < SD_PINS; i++) begin
            if (sd_sel == SEL_W'(i)) sd_bit = sd_sy1[i];
        end
    end

    // bit counter, shift register and byte strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev   <= 1'b0;
            locked    <= 1'b0;
            sof_pend  <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            byte_data <= '0;
            byte_sof  <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (samp) begin
                ws_prev <= ws_sy[1];
                if (wsr) begin
                    shreg    <= {6'b0, sd_bit};
                    bit_cnt  <= 3'd1;
                    sof_pend <= 1'b1;
                    locked   <= 1'b1;
                end else begin
                    shreg   <= {shreg[5:0], sd_bit};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (locked && bit_cnt == 3'd7) begin
                        byte_done <= 1'b1;
                        byte_data <= {shreg, sd_bit};
                        byte_sof  <= sof_pend;
                        sof_pend  <= 1'b0;
                    end
                end
            end
        end
    end

    // R2: a byte strobe lasts one cycle; bytes are 8 bit times apart
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);
endmodule

// File: rtl/tdm_slot_table.sv
// Slot table: one 8-bit entry per slot, written by software, read
// combinationally by slot index. Assumes SLOTS is a power of two.
module tdm_slot_table #(
    parameter int SLOTS  = 32,
    parameter int IDX_W  = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] entry_q [SLOTS];

    // software write port, reset leaves every entry invalid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) entry_q[i] <= '0;
        end else if (wr_en) begin
            entry_q[wr_idx] <= wr_data;
        end
    end

    // lookup for the slot currently completing
    assign rd_data = entry_q[rd_idx];
endmodule

// File: rtl/tdm_dword_fifo.sv
// Input FIFO: DEPTH words of W bits with fall-through head, any depth
// (not only powers of two). Assumes push is never raised while full.
module tdm_dword_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // pointers with wrap at DEPTH and occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + PW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + PW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R7: occupancy never exceeds the depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);
    // R7: a lone accepted push grows the occupancy by one
    a_r7_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (count == $past(count) + CW'(1)));
    // R7: a lone pop of a non-empty FIFO shrinks it by one
    a_r7_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/tdm_capture_router.sv
// Top: receives serial TDM audio, looks up each slot's entry, steers the
// byte into an assembly lane or a feedback buffer, stores words into the
// input FIFO and flags drops on a full FIFO. Assumes clk >> bclk.
module tdm_capture_router #(
    parameter int SD_PINS    = 5,
    parameter int SLOTS      = 32,
    parameter int FIFO_DEPTH = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bclk,
    input  logic        ws,
    input  logic [4:0]  sd,
    input  logic [2:0]  sd_sel,
    input  logic        bclk_inv,
    input  logic        tsl_we,
    input  logic [4:0]  tsl_addr,
    input  logic [7:0]  tsl_wdata,
    input  logic        fb_we,
    input  logic        fb_sel,
    input  logic [31:0] fb_wdata,
    output logic [31:0] fb1_q,
    output logic [31:0] fb2_q,
    output logic        pop_valid,
    output logic [31:0] pop_data,
    input  logic        pop_ready,
    output logic        overflow
);
    import tdm_pkg::*;

    localparam int LANES  = 4;
    localparam int WORD_W = 8 * LANES;
    localparam int IDX_W  = $clog2(SLOTS);
    localparam int SEL_W  = $clog2(SD_PINS);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);

    logic              byte_done;
    logic [7:0]        byte_data;
    logic              byte_sof;
    logic [IDX_W-1:0]  slot_idx;
    logic [IDX_W-1:0]  cur_slot;
    logic [7:0]        entry_raw;
    slot_entry_t       entry;
    logic [WORD_W-1:0] asm_q;
    logic [WORD_W-1:0] asm_next;
    logic              push_req;
    logic              fifo_full;
    logic              fifo_empty;
    logic              fifo_push;
    logic              fifo_pop;
    logic              drop;
    logic [31:0]       fb_q [2];

    tdm_bit_rx #(.SD_PINS(SD_PINS), .SEL_W(SEL_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .ws       (ws),
        .sd       (sd[SD_PINS-1:0]),
        .sd_sel   (sd_sel[SEL_W-1:0]),
        .bclk_inv (bclk_inv),
        .byte_done(byte_done),
        .byte_data(byte_data),
        .byte_sof (byte_sof)
    );

    tdm_slot_table #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tsl_we),
        .wr_idx (tsl_addr[IDX_W-1:0]),
        .wr_data(tsl_wdata),
        .rd_idx (cur_slot),
        .rd_data(entry_raw)
    );

    tdm_dword_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fifo_push),
        .push_data(asm_next),
        .pop      (fifo_pop),
        .head     (pop_data),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

    // slot of the completing byte: a frame start forces slot 0
    assign cur_slot = byte_sof ? '0 : slot_idx;
    assign entry    = slot_entry_t'(entry_raw);

    // assembly word with the current byte merged into its lane
    always_comb begin
        asm_next = asm_q;
        if (byte_done && entry.valid && entry.dest[3:2] == GRP_LANE) begin
            asm_next[entry.dest[1:0]*8 +: 8] = byte_data;
        end
    end

    assign push_req  = byte_done && entry.valid && entry.store;
    assign fifo_push = push_req && !fifo_full;
    assign drop      = push_req && fifo_full;
    assign fifo_pop  = pop_ready && !fifo_empty;
    assign pop_valid = !fifo_empty;

    // slot index advance with wrap at end-of-frame or last slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_idx <= '0;
        end else if (byte_done) begin
            slot_idx <= (entry.eof || cur_slot == LAST_SLOT) ? '0 : cur_slot + IDX_W'(1);
        end
    end

    // assembly register, cleared after each store request
    always_ff @(posedge clk) begin
        if (!rst_n)        asm_q <= '0;
        else if (push_req) asm_q <= '0;
        else               asm_q <= asm_next;
    end

    // sticky overflow on a dropped store
    always_ff @(posedge clk) begin
        if (!rst_n)    overflow <= 1'b0;
        else if (drop) overflow <= 1'b1;
    end

    // feedback buffers: software write wins over captured byte
    for (genvar g = 0; g < 2; g++) begin : g_fb
        localparam logic [1:0] GRP = (g == 0) ? GRP_FB1 : GRP_FB2;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fb_q[g] <= '0;
            end else if (fb_we && fb_sel == 1'(g)) begin
                fb_q[g] <= fb_wdata;
            end else if (byte_done && entry.valid && entry.dest[3:2] == GRP) begin
                fb_q[g][entry.dest[1:0]*8 +: 8] <= byte_data;
            end
        end
    end

    assign fb1_q = fb_q[0];
    assign fb2_q = fb_q[1];

    // R8: overflow, once set, stays set
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R6: an end-of-frame entry sends the next slot back to 0
    a_r6_eof_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && entry.eof) |=> (slot_idx == '0));
    // R5: an invalid entry leaves both feedback buffers untouched
    a_r5_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !entry.valid && !fb_we) |=> ($stable(fb1_q) && $stable(fb2_q)));
    // R8: a store into a full FIFO leaves pop_valid high
    a_r8_full_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !pop_ready) |=> pop_valid);
endmodule

// File: tb/test_tdm_capture_router.sv
module test_tdm_capture_router;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        ws = 1'b0;
    logic [4:0]  sd = '0;
    logic [2:0]  sd_sel = '0;
    logic        bclk_inv = 1'b0;
    logic        tsl_we = 1'b0;
    logic [4:0]  tsl_addr = '0;
    logic [7:0]  tsl_wdata = '0;
    logic        fb_we = 1'b0;
    logic        fb_sel = 1'b0;
    logic [31:0] fb_wdata = '0;
    logic [31:0] fb1_q, fb2_q, pop_data;
    logic        pop_valid, overflow;
    logic        pop_ready = 1'b1;

    int errors = 0;
    int checks = 0;
    int pops   = 0;

    logic [31:0] exp_q[$];
    logic [7:0]  tbl_m [32];
    logic [31:0] asm_m;
    logic [31:0] fb_m [2];
    int          slot_m;
    bit          hold_mode;
    bit          ovf_m;
    logic [7:0]  frame_b [32];

    tdm_capture_router i_tdm_capture_router (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .ws(ws), .sd(sd),
        .sd_sel(sd_sel), .bclk_inv(bclk_inv), .tsl_we(tsl_we),
        .tsl_addr(tsl_addr), .tsl_wdata(tsl_wdata), .fb_we(fb_we),
        .fb_sel(fb_sel), .fb_wdata(fb_wdata), .fb1_q(fb1_q), .fb2_q(fb2_q),
        .pop_valid(pop_valid), .pop_data(pop_data), .pop_ready(pop_ready),
        .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compare each popped word in order
    always @(negedge clk) begin
        if (rst_n && pop_valid && pop_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected word", pop_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(pop_data == e, "R3/R7 word", pop_data, e);
            end
            pops++;
        end
    end

    task automatic tsl_write(input int a, input logic [7:0] d);
        @(negedge clk);
        tsl_we = 1'b1; tsl_addr = 5'(a); tsl_wdata = d;
        @(negedge clk);
        tsl_we = 1'b0;
        tbl_m[a] = d;
    endtask

    task automatic fb_write(input bit s, input logic [31:0] d);
        @(negedge clk);
        fb_we = 1'b1; fb_sel = s; fb_wdata = d;
        @(negedge clk);
        fb_we = 1'b0;
        fb_m[s] = d;
    endtask

    // reference model of one slot, from the requirements
    task automatic model_byte(input logic [7:0] b, input bit sof);
        int cur;
        logic [7:0] e;
        int d;
        cur = sof ? 0 : slot_m;
        e = tbl_m[cur];
        d = int'(e[3:0]);
        if (e[7]) begin
            if (d < 4)       asm_m[d*8 +: 8] = b;
            else if (d < 8)  fb_m[0][(d-4)*8 +: 8] = b;
            else if (d < 12) fb_m[1][(d-8)*8 +: 8] = b;
            if (e[6]) begin
                if (hold_mode && exp_q.size() >= 24) ovf_m = 1'b1;
                else exp_q.push_back(asm_m);
                asm_m = '0;
            end
        end
        slot_m = (e[5] || cur == 31) ? 0 : cur + 1;
    endtask

    task automatic send_bit(input logic b, input logic w);
        @(negedge clk);
        bclk = bclk_inv;
        ws = w;
        for (int i = 0; i < 5; i++) sd[i] = (3'(i) == sd_sel) ? b : ~b;
        repeat (HALF) @(negedge clk);
        bclk = ~bclk_inv;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_frame(input int n);
        for (int s = 0; s < n; s++) begin
            model_byte((sd_sel <= 3'd4) ? frame_b[s] : 8'h00, s == 0);
            for (int k = 7; k >= 0; k--) send_bit(frame_b[s][k], s == 0 && k == 7);
        end
        send_bit(1'b0, 1'b0);
        repeat (12) @(negedge clk);
    endtask

    task automatic set_ready(input logic r);
        @(posedge clk);
        #(CLK_PERIOD/4);
        pop_ready = r;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p0;
        for (int i = 0; i < 32; i++) tbl_m[i] = '0;
        asm_m = '0; fb_m[0] = '0; fb_m[1] = '0; slot_m = 0;
        hold_mode = 0; ovf_m = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(pop_valid == 1'b0, "R1 pop_valid", 32'(pop_valid), 32'h0);
        chk(overflow == 1'b0, "R1 overflow", 32'(overflow), 32'h0);
        chk(fb1_q == 32'h0, "R1 fb1", fb1_q, 32'h0);
        chk(fb2_q == 32'h0, "R1 fb2", fb2_q, 32'h0);

        // table A: lanes 0..3 with store, feedback bytes, an invalid slot, eof
        tsl_write(0, 8'h80); tsl_write(1, 8'h81); tsl_write(2, 8'h82);
        tsl_write(3, 8'hC3); tsl_write(4, 8'h84); tsl_write(5, 8'h89);
        tsl_write(6, 8'h0B); tsl_write(7, 8'hE2);
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);

        // R2/R3/R4/R5: two frames with distinct data
        frame_b[0] = 8'h12; frame_b[1] = 8'h34; frame_b[2] = 8'h56; frame_b[3] = 8'h78;
        frame_b[4] = 8'hA5; frame_b[5] = 8'h3C; frame_b[6] = 8'hEE; frame_b[7] = 8'h81;
        send_frame(8);
        chk(fb1_q == fb_m[0], "R4 fb1 byte0", fb1_q, fb_m[0]);
        chk(fb2_q == fb_m[1], "R4 fb2 byte1", fb2_q, fb_m[1]);
        frame_b[0] = 8'hF0; frame_b[1] = 8'h0F; frame_b[2] = 8'hC3; frame_b[3] = 8'h96;
        frame_b[4] = 8'h5A; frame_b[5] = 8'h01; frame_b[6] = 8'h7E; frame_b[7] = 8'hFF;
        send_frame(8);
        chk(fb1_q == fb_m[0] && fb2_q == fb_m[1], "R5 invalid slot ignored", fb1_q, fb_m[0]);
        chk(exp_q.size() == 0, "R2 words drained", 32'(exp_q.size()), 32'h0);

        // R6: frame longer than eof position wraps to slot 0
        p0 = pops;
        for (int i = 0; i < 12; i++) frame_b[i] = 8'(8'h20 + i * 7);
        send_frame(12);
        chk(pops - p0 == 3, "R6 wrap words", 32'(pops - p0), 32'd3);

        // R9: sampling on falling edges
        bclk_inv = 1'b1;
        @(negedge clk); bclk = 1'b1;
        repeat (8) @(negedge clk);
        p0 = pops;
        for (int i = 0; i < 8; i++) frame_b[i] = 8'(8'h9B ^ (i * 8'h11));
        send_frame(8);
        chk(pops - p0 == 2, "R9 inverted words", 32'(pops - p0), 32'd2);
        chk(fb1_q == fb_m[0], "R9 inverted fb1", fb1_q, fb_m[0]);
        bclk_inv = 1'b0;
        @(negedge clk); bclk = 1'b0;
        repeat (8) @(negedge clk);

        // R10: other pin, then an out-of-range select
        sd_sel = 3'd2;
        for (int i = 0; i < 8; i++) frame_b[i] = 8'(8'h47 + i * 13);
        send_frame(8);
        chk(fb2_q == fb_m[1], "R10 pin 2 fb2", fb2_q, fb_m[1]);
        sd_sel = 3'd6;
        send_frame(8);
        chk(fb1_q == fb_m[0], "R10 select 6 zeros", fb1_q, fb_m[0]);
        sd_sel = 3'd4;
        send_frame(8);
        chk(fb1_q == fb_m[0], "R10 pin 4 fb1", fb1_q, fb_m[0]);
        chk(exp_q.size() == 0, "R10 words drained", 32'(exp_q.size()), 32'h0);

        // R11: software writes to the feedback buffers
        fb_write(1'b0, 32'hCAFE_F00D);
        @(negedge clk);
        chk(fb1_q == 32'hCAFE_F00D, "R11 fb1 write", fb1_q, 32'hCAFE_F00D);
        fb_write(1'b1, 32'h1357_9BDF);
        @(negedge clk);
        chk(fb2_q == 32'h1357_9BDF, "R11 fb2 write", fb2_q, 32'h1357_9BDF);
        chk(fb1_q == 32'hCAFE_F00D, "R11 fb1 kept", fb1_q, 32'hCAFE_F00D);

        // R8: 26 stores with the consumer stalled
        for (int i = 0; i < 26; i++) tsl_write(i, (i == 25) ? 8'hE0 : 8'hC0);
        set_ready(1'b0);
        hold_mode = 1;
        for (int i = 0; i < 26; i++) frame_b[i] = 8'(i + 1);
        send_frame(26);
        chk(overflow == ovf_m && ovf_m, "R8 overflow set", 32'(overflow), 32'h1);
        chk(pop_valid == 1'b1, "R7 full fifo valid", 32'(pop_valid), 32'h1);
        hold_mode = 0;
        p0 = pops;
        set_ready(1'b1);
        repeat (40) @(negedge clk);
        chk(pops - p0 == 24, "R7 depth 24", 32'(pops - p0), 32'd24);
        chk(exp_q.size() == 0, "R7 order drained", 32'(exp_q.size()), 32'h0);
        chk(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 32'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule